// File: doc/BRIEF.md
# Relative Branch Condition Evaluator

This block decides the outcome of the relative-branch instructions of an 8-bit accumulator machine. For each accepted opcode it reports three things: whether the opcode is a relative branch, whether the branch is taken, and where execution continues. It also reports the cost of the branch in half-cycles, because a taken branch costs half a cycle more than one that falls through.

The decision depends on the opcode family. Two families carry a flag-select mask in their low bits instead of a fixed condition code. In the any-set family, the branch is taken when at least one selected flag is 1. In the all-clear family, the branch is taken only when every selected flag is 0. One further opcode tests the low bits of the scratchpad index register and branches unless they are all ones. With an empty mask, the all-clear family gives the unconditional relative branch.

The displacement is a signed byte. It is added to the address of the displacement byte itself, and the fall-through address is the byte after it. The sequencer presents one opcode with its operands per `in_valid` pulse. The results appear on the registered outputs one clock later and stay there until the next accepted opcode.

Top module: `rel_branch_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is driven to zero.
- R2: An opcode presented with `in_valid` high produces its results one clock later, with `out_valid` high for exactly that cycle.
- R3: When `in_valid` is low, `out_valid` goes low and all other outputs keep their previous values, regardless of the other inputs.
- R4: Opcodes 0x80 to 0x87 select flags by bit 0 = S, bit 1 = C and bit 2 = Z. They are taken when any selected flag is 1, so 0x80 is never taken.
- R5: Opcodes 0x90 to 0x9F select flags by bit 0 = S, bit 1 = C, bit 2 = Z and bit 3 = O. They are taken only when every selected flag is 0, so 0x90 is always taken.
- R6: Opcode 0x8F is taken exactly when `isar_lo` is not all ones, and the four flags have no effect on it.
- R7: `target` equals `pc` plus the sign-extended `disp`, modulo 2^ADDR_W, for every accepted opcode, taken or not.
- R8: `next_pc` equals `target` when the branch is taken, and otherwise equals `pc` + 1 modulo 2^ADDR_W.
- R9: For a branch opcode, `half_cycles` is 7 when taken and 6 when not taken.
- R10: Any opcode outside 0x80–0x87, 0x8F and 0x90–0x9F gives `is_branch` = 0, `taken` = 0 and `half_cycles` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Opcode and operands are presented this cycle |
| opcode | input | 8 | Instruction opcode byte |
| disp | input | DISP_W (8) | Signed displacement byte |
| pc | input | ADDR_W (16) | Address of the displacement byte |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Overflow flag |
| isar_lo | input | ISAR_W (3) | Low bits of the scratchpad index register |
| out_valid | output | 1 | Results below belong to the opcode accepted last cycle |
| is_branch | output | 1 | Opcode is one of the relative branches |
| taken | output | 1 | Branch is taken |
| target | output | ADDR_W (16) | pc plus the sign-extended displacement |
| next_pc | output | ADDR_W (16) | Address where execution continues |
| half_cycles | output | HC_W (4) | Branch cost in half machine cycles |

## Verification
The bench uses the default configuration: 16-bit addresses, an 8-bit displacement and a 3-bit index field. With these widths every one of the 256 opcodes can be driven against all 16 flag combinations, and every index value is paired with each opcode. This covers every mask value of both families, every flag that a mask ignores, and every opcode outside the branch set. The 16-bit address also lets directed cases push the adder across 0xFFFF and 0x0000 in both directions. These cases include a fall-through from the top address.

// File: rtl/rbu_pkg.sv
// Shared definitions for the relative branch unit.
// Assumes the opcode byte is always 8 bits wide.
package rbu_pkg;

    // Number of condition flags that a mask can select.
    localparam int NFLAGS = 4;

    // Bit positions of the flags inside the flag vector (mask bit order).
    localparam int FLG_S = 0;
    localparam int FLG_C = 1;
    localparam int FLG_Z = 2;
    localparam int FLG_O = 3;

    // Opcode families recognised by the decoder.
    typedef enum logic [1:0] {
        FAM_NONE    = 2'd0,   // not a relative branch
        FAM_ANY_SET = 2'd1,   // taken if any selected flag is 1
        FAM_ALL_CLR = 2'd2,   // taken if every selected flag is 0
        FAM_OCTAL   = 2'd3    // taken if index low bits are not all ones
    } fam_e;

endpackage

// File: rtl/rbu_decode.sv
// Opcode classifier: maps an opcode byte to its branch family and the
// flag-select mask carried in its low bits.
// Assumes the 0x8F index test takes priority over the 0x88-0x8E range,
// which is not a branch.
module rbu_decode
    import rbu_pkg::*;
(
    input  logic [7:0]        opcode,
    output fam_e              fam,
    output logic [NFLAGS-1:0] mask
);

    // Classify the opcode and extract its mask field.
    always_comb begin
        fam  = FAM_NONE;
        mask = '0;
        if (opcode[7:3] == 5'b10000) begin
            fam  = FAM_ANY_SET;
            mask = {1'b0, opcode[2:0]};
        end else if (opcode == 8'h8F) begin
            fam  = FAM_OCTAL;
        end else if (opcode[7:4] == 4'h9) begin
            fam  = FAM_ALL_CLR;
            mask = opcode[3:0];
        end
    end

endmodule

// File: rtl/rbu_cond.sv
// Condition evaluator: decides whether the decoded branch is taken.
// Assumes the flag vector uses the same bit order as the mask.
module rbu_cond
    import rbu_pkg::*;
#(
    parameter int ISAR_W = 3
) (
    input  fam_e              fam,
    input  logic [NFLAGS-1:0] mask,
    input  logic [NFLAGS-1:0] flags,
    input  logic [ISAR_W-1:0] isar_lo,
    output logic              is_br,
    output logic              taken
);

    logic [NFLAGS-1:0] hit;

    // One gate per flag: the flag counts only if the mask selects it.
    genvar gi;
    generate
        for (gi = 0; gi < NFLAGS; gi++) begin : g_hit
            assign hit[gi] = mask[gi] & flags[gi];
        end
    endgenerate

    // Reduce the selected flags according to the family.
    always_comb begin
        is_br = 1'b1;
        taken = 1'b0;
        unique case (fam)
            FAM_ANY_SET: taken = |hit;
            FAM_ALL_CLR: taken = ~|hit;
            FAM_OCTAL:   taken = (isar_lo != {ISAR_W{1'b1}});
            default:     is_br = 1'b0;
        endcase
    end

endmodule

// File: rtl/rbu_addr.sv
// Address generator: forms the relative target and the fall-through
// address. Assumes pc points at the displacement byte and that the
// arithmetic wraps modulo 2^ADDR_W.
module rbu_addr #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] seq
);

    logic [ADDR_W-1:0] disp_ext;

    // Sign-extend (or trim) the displacement to the address width.
    generate
        if (ADDR_W > DISP_W) begin : g_ext
            assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        end else begin : g_trim
            assign disp_ext = disp[ADDR_W-1:0];
        end
    endgenerate

    // Both candidate addresses are computed in parallel.
    always_comb begin
        target = pc + disp_ext;
        seq    = pc + ADDR_W'(1);
    end

endmodule

// File: rtl/rel_branch_unit.sv
// Relative branch unit: evaluates one branch opcode per in_valid pulse and
// registers taken, target, next address and half-cycle cost.
// Assumes flags, index bits and pc are stable in the cycle in_valid is high.
module rel_branch_unit
    import rbu_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DISP_W       = 8,
    parameter int ISAR_W       = 3,
    parameter int HC_W         = 4,
    parameter int HC_NOT_TAKEN = 6,
    parameter int HC_TAKEN     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] pc,
    input  logic              flag_c,
    input  logic              flag_z,
    input  logic              flag_s,
    input  logic              flag_o,
    input  logic [ISAR_W-1:0] isar_lo,
    output logic              out_valid,
    output logic              is_branch,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] next_pc,
    output logic [HC_W-1:0]   half_cycles
);

    localparam logic [HC_W-1:0] HC_TK = HC_W'(HC_TAKEN);
    localparam logic [HC_W-1:0] HC_NT = HC_W'(HC_NOT_TAKEN);

    fam_e              fam;
    logic [NFLAGS-1:0] mask;
    logic [NFLAGS-1:0] flags;
    logic              br_c;
    logic              tk_c;
    logic [ADDR_W-1:0] tgt_c;
    logic [ADDR_W-1:0] seq_c;
    logic [HC_W-1:0]   hc_c;

    // Gather the flags in mask bit order.
    always_comb begin
        flags        = '0;
        flags[FLG_S] = flag_s;
        flags[FLG_C] = flag_c;
        flags[FLG_Z] = flag_z;
        flags[FLG_O] = flag_o;
    end

    rbu_decode u_dec (
        .opcode (opcode),
        .fam    (fam),
        .mask   (mask)
    );

    rbu_cond #(.ISAR_W(ISAR_W)) u_cond (
        .fam     (fam),
        .mask    (mask),
        .flags   (flags),
        .isar_lo (isar_lo),
        .is_br   (br_c),
        .taken   (tk_c)
    );

    rbu_addr #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
        .pc     (pc),
        .disp   (disp),
        .target (tgt_c),
        .seq    (seq_c)
    );

    // Select the branch cost; non-branch opcodes report zero.
    always_comb begin
        if (!br_c)     hc_c = '0;
        else if (tk_c) hc_c = HC_TK;
        else           hc_c = HC_NT;
    end

    // Output register: load on in_valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            is_branch   <= 1'b0;
            taken       <= 1'b0;
            target      <= '0;
            next_pc     <= '0;
            half_cycles <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                is_branch   <= br_c;
                taken       <= tk_c;
                target      <= tgt_c;
                next_pc     <= tk_c ? tgt_c : seq_c;
                half_cycles <= hc_c;
            end
        end
    end

endmodule

// File: rtl/rbu_checker.sv
// Property checker for rel_branch_unit, attached by bind below.
// Assumes the bound unit's default-or-given parameters are passed in.
module rbu_checker #(
    parameter int ADDR_W       = 16,
    parameter int DISP_W       = 8,
    parameter int ISAR_W       = 3,
    parameter int HC_W         = 4,
    parameter int HC_NOT_TAKEN = 6,
    parameter int HC_TAKEN     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        opcode,
    input logic [DISP_W-1:0] disp,
    input logic [ADDR_W-1:0] pc,
    input logic              flag_c,
    input logic              flag_z,
    input logic              flag_s,
    input logic              flag_o,
    input logic [ISAR_W-1:0] isar_lo,
    input logic              out_valid,
    input logic              is_branch,
    input logic              taken,
    input logic [ADDR_W-1:0] target,
    input logic [ADDR_W-1:0] next_pc,
    input logic [HC_W-1:0]   half_cycles
);

    logic warm;

    // Marks cycles whose previous edge already followed a reset edge.
    always_ff @(posedge clk) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        warm && !$past(in_valid) |-> !out_valid && $stable(taken) &&
        $stable(target) && $stable(next_pc) && $stable(half_cycles) &&
        $stable(is_branch));

    a_r5_uncond: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(in_valid) && $past(opcode) == 8'h90 |-> taken);

    a_r6_octal: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(in_valid) && $past(opcode) == 8'h8F |->
        taken == ($past(isar_lo) != {ISAR_W{1'b1}}));

    a_r8_taken_next: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && taken |-> next_pc == target);

    a_r8_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        warm && out_valid && !taken |-> next_pc == ADDR_W'($past(pc) + 1'b1));

    a_r9_cost: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && is_branch |->
        half_cycles == (taken ? HC_W'(HC_TAKEN) : HC_W'(HC_NOT_TAKEN)));

    a_r10_other: assert property (@(posedge clk) disable iff (!rst_n)
        !is_branch |-> !taken && half_cycles == '0);

    // Inputs observed only for completeness of the bound port list.
    logic unused_ok;
    assign unused_ok = ^{disp, flag_c, flag_z, flag_s, flag_o};

endmodule

bind rel_branch_unit rbu_checker #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .ISAR_W(ISAR_W), .HC_W(HC_W),
    .HC_NOT_TAKEN(HC_NOT_TAKEN), .HC_TAKEN(HC_TAKEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .disp(disp), .pc(pc), .flag_c(flag_c), .flag_z(flag_z),
    .flag_s(flag_s), .flag_o(flag_o), .isar_lo(isar_lo),
    .out_valid(out_valid), .is_branch(is_branch), .taken(taken),
    .target(target), .next_pc(next_pc), .half_cycles(half_cycles)
);

// File: tb/rel_branch_unit_test.sv
// Sweep bench for rel_branch_unit: every opcode against every flag set.
module rel_branch_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  disp = '0;
    logic [15:0] pc = '0;
    logic        flag_c = 1'b0, flag_z = 1'b0, flag_s = 1'b0, flag_o = 1'b0;
    logic [2:0]  isar_lo = '0;
    logic        out_valid, is_branch, taken;
    logic [15:0] target, next_pc;
    logic [3:0]  half_cycles;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rel_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .disp(disp), .pc(pc), .flag_c(flag_c), .flag_z(flag_z),
        .flag_s(flag_s), .flag_o(flag_o), .isar_lo(isar_lo),
        .out_valid(out_valid), .is_branch(is_branch), .taken(taken),
        .target(target), .next_pc(next_pc), .half_cycles(half_cycles)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_is_br(input logic [7:0] op);
        return (op[7:3] == 5'b10000) || (op == 8'h8F) || (op[7:4] == 4'h9);
    endfunction

    function automatic bit model_taken(input logic [7:0] op, input logic [3:0] f,
                                       input logic [2:0] ix);
        // f bit order: 0 = S, 1 = C, 2 = Z, 3 = O
        if (op[7:3] == 5'b10000) return (op[2:0] & f[2:0]) != 3'b000;
        if (op == 8'h8F)         return ix != 3'd7;
        if (op[7:4] == 4'h9)     return (op[3:0] & f) == 4'b0000;
        return 1'b0;
    endfunction

    // Apply one opcode, wait one cycle and compare every output.
    task automatic run_one(input logic [7:0] op, input logic [3:0] f,
                           input logic [2:0] ix, input logic [15:0] p,
                           input logic [7:0] d);
        bit br, tk;
        logic [15:0] tgt, nxt;
        string rq;
        in_valid = 1'b1; opcode = op; disp = d; pc = p; isar_lo = ix;
        flag_s = f[0]; flag_c = f[1]; flag_z = f[2]; flag_o = f[3];
        @(negedge clk);
        br  = model_is_br(op);
        tk  = model_taken(op, f, ix);
        tgt = 16'((int'(p) + int'($signed(d))) & 32'hFFFF);
        nxt = tk ? tgt : 16'(p + 16'd1);
        if (op[7:3] == 5'b10000)  rq = "R4";
        else if (op == 8'h8F)     rq = "R6";
        else if (op[7:4] == 4'h9) rq = "R5";
        else                      rq = "R10";
        chk("R2", "out_valid", 32'(out_valid), 32'd1);
        chk(rq, "is_branch", 32'(is_branch), 32'(br));
        chk(rq, "taken", 32'(taken), 32'(tk));
        chk("R7", "target", 32'(target), 32'(tgt));
        chk("R8", "next_pc", 32'(next_pc), 32'(nxt));
        chk(br ? "R9" : "R10", "half_cycles", 32'(half_cycles),
            br ? (tk ? 32'd7 : 32'd6) : 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        logic [15:0] t_h, n_h;
        logic [3:0]  hc_h;
        logic        tk_h, br_h;
        // R1: reset with busy inputs.
        in_valid = 1'b1; opcode = 8'h90; disp = 8'h7F; pc = 16'h1234;
        repeat (3) @(negedge clk);
        chk("R1", "out_valid", 32'(out_valid), 32'd0);
        chk("R1", "taken", 32'(taken), 32'd0);
        chk("R1", "target", 32'(target), 32'd0);
        chk("R1", "next_pc", 32'(next_pc), 32'd0);
        chk("R1", "half_cycles", 32'(half_cycles), 32'd0);
        chk("R1", "is_branch", 32'(is_branch), 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Full sweep: all opcodes, all flag sets, all index values across f.
        for (int op = 0; op < 256; op++) begin
            for (int f = 0; f < 16; f++) begin
                run_one(8'(op), 4'(f), 3'(f) ^ 3'(op),
                        16'((op << 8) | (f << 4) | 3) ^ 16'hA5C0,
                        8'(op * 7 + f * 29));
            end
        end

        // R7/R8 wrap-around corners.
        run_one(8'h90, 4'h0, 3'd0, 16'hFFFF, 8'h01);   // forward past top
        chk("R7", "wrap up", 32'(target), 32'h0000);
        run_one(8'h90, 4'h0, 3'd0, 16'h0005, 8'h80);   // backward past zero
        chk("R7", "wrap down", 32'(target), 32'hFF85);
        run_one(8'h80, 4'hF, 3'd0, 16'hFFFF, 8'h10);   // never taken at top
        chk("R8", "fallthrough wrap", 32'(next_pc), 32'h0000);
        // R6: flags have no effect on 0x8F.
        run_one(8'h8F, 4'hF, 3'd7, 16'h0100, 8'h20);
        run_one(8'h8F, 4'h0, 3'd6, 16'h0100, 8'h20);

        // R3: idle cycle with changed inputs holds the last result.
        run_one(8'h94, 4'h0, 3'd1, 16'h4000, 8'hF0);
        t_h = target; n_h = next_pc; hc_h = half_cycles; tk_h = taken; br_h = is_branch;
        in_valid = 1'b0; opcode = 8'h80; pc = 16'h0BAD; disp = 8'h01;
        flag_z = 1'b1; isar_lo = 3'd7;
        @(negedge clk);
        chk("R3", "out_valid idle", 32'(out_valid), 32'd0);
        chk("R3", "target held", 32'(target), 32'(t_h));
        chk("R3", "next_pc held", 32'(next_pc), 32'(n_h));
        chk("R3", "half_cycles held", 32'(half_cycles), 32'(hc_h));
        chk("R3", "taken held", 32'(taken), 32'(tk_h));
        chk("R3", "is_branch held", 32'(is_branch), 32'(br_h));
        @(negedge clk);
        chk("R2", "out_valid one cycle", 32'(out_valid), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule